// File: doc/BRIEF.md
# Three-Entry Shared-Address Register File

This block holds a small bank of general-purpose registers, three of them by default, each one byte wide. It has two read ports and a single write port. The write destination and the port B read source are the same address field. One mode input decides what the bank does in a given cycle. When the mode is low, the value on the data input is stored into the register that the shared address selects. When the mode is high, the registers are left untouched.

Ports A and B always show, combinationally, the registers chosen by their addresses. In write mode they therefore show the contents from before the write. The highest address value selects no register. A synchronous clear input sets every register to zero. A flattened display output shows all registers at all times. Registers update on the falling clock edge.

Top module: `regfile_trio`

## Requirements
- R1: When `clr` is high at a falling clock edge, all registers read zero after that edge.
- R2: When `rd_mode` is 0 and `clr` is low, the falling edge stores `wr_data` into the register indexed by `addr_wb` (0, 1 or 2). All other registers are unchanged.
- R3: When `rd_mode` is 1 and `clr` is low, no register changes at the falling edge.
- R4: `port_a` equals the register indexed by `addr_a` in both modes.
- R5: `port_b` equals the register indexed by `addr_wb` in both modes.
- R6: A write with `addr_wb` = 3 changes no register.
- R7: A read port whose address is 3 outputs zero.
- R8: When `clr` and a write occur at the same edge, the clear wins and every register is zero.
- R9: In write mode, `port_a` and `port_b` show the register contents from before the edge until the falling edge occurs.
- R10: `disp_regs` always carries register i in bits [8*i+7 : 8*i].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; state changes on the falling edge |
| clr | input | 1 | Synchronous active-high clear of all registers |
| rd_mode | input | 1 | 0 = write mode, 1 = read-only mode |
| addr_a | input | 2 | Port A read address |
| addr_wb | input | 2 | Shared write and port B read address |
| wr_data | input | 8 | Data to store in write mode |
| port_a | output | 8 | Register selected by addr_a, or zero |
| port_b | output | 8 | Register selected by addr_wb, or zero |
| disp_regs | output | 24 | All registers, register i in byte lane i |

## Verification
The bench builds the block with its default parameters: three registers of 8 bits and 2-bit addresses. With that configuration, every address pair, including the unused address 3, can be swept in both modes. Written values come from an arithmetic formula of address and pass number, so every bit lane toggles. Every register's contents are known before each read-port combination is checked. Clear is exercised alone and together with a write to each address.

// File: rtl/regfile_trio_pkg.sv
package regfile_trio_pkg;
  localparam int unsigned DEF_DATA_W   = 8;
  localparam int unsigned DEF_NUM_REGS = 3;

  typedef enum logic {
    MODE_WRITE = 1'b0,
    MODE_READ  = 1'b1
  } rf_mode_e;
endpackage

// File: rtl/regfile_slot.sv
module regfile_slot #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              clr,
  input  logic              we,
  input  logic [DATA_W-1:0] d,
  output logic [DATA_W-1:0] q
);
  logic clr_seen;

  always_ff @(negedge clk) begin
    if (clr)     q <= '0;
    else if (we) q <= d;
  end

  always_ff @(negedge clk) clr_seen <= clr;

  always @(negedge clk) begin
    if (clr_seen) AST_SLOT_CLEAR: assert (q == '0); // R1
  end

  AST_SLOT_LOAD: assert property (@(negedge clk) disable iff (clr)
    we |=> (q == $past(d))); // R2

  AST_SLOT_HOLD: assert property (@(negedge clk) disable iff (clr)
    !we |=> $stable(q)); // R3
endmodule

// File: rtl/regfile_rdport.sv
module regfile_rdport #(
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned NUM_REGS = 3,
  parameter int unsigned ADDR_W   = 2
) (
  input  logic [NUM_REGS*DATA_W-1:0] regs,
  input  logic [ADDR_W-1:0]          addr,
  output logic [DATA_W-1:0]          dout
);
  always_comb begin
    dout = '0;
    for (int i = 0; i < NUM_REGS; i++) begin
      if (addr == ADDR_W'(i)) dout = regs[i*DATA_W +: DATA_W];
    end
  end

  always_comb begin
    if (int'(addr) >= NUM_REGS) AST_NULL_READ: assert (dout == '0); // R7
  end
endmodule

// File: rtl/regfile_trio.sv
module regfile_trio
  import regfile_trio_pkg::*;
#(
  parameter int unsigned DATA_W   = DEF_DATA_W,
  parameter int unsigned NUM_REGS = DEF_NUM_REGS,
  parameter int unsigned ADDR_W   = $clog2(NUM_REGS + 1)
) (
  input  logic                       clk,
  input  logic                       clr,
  input  logic                       rd_mode,
  input  logic [ADDR_W-1:0]          addr_a,
  input  logic [ADDR_W-1:0]          addr_wb,
  input  logic [DATA_W-1:0]          wr_data,
  output logic [DATA_W-1:0]          port_a,
  output logic [DATA_W-1:0]          port_b,
  output logic [NUM_REGS*DATA_W-1:0] disp_regs
);
  rf_mode_e mode;
  assign mode = rf_mode_e'(rd_mode);

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_slot
    logic sel_we;
    assign sel_we = (mode == MODE_WRITE) && (addr_wb == ADDR_W'(g));
    regfile_slot #(.DATA_W(DATA_W)) i_slot (
      .clk (clk),
      .clr (clr),
      .we  (sel_we),
      .d   (wr_data),
      .q   (disp_regs[g*DATA_W +: DATA_W])
    );
  end

  regfile_rdport #(.DATA_W(DATA_W), .NUM_REGS(NUM_REGS), .ADDR_W(ADDR_W)) i_rd_a (
    .regs (disp_regs),
    .addr (addr_a),
    .dout (port_a)
  );

  regfile_rdport #(.DATA_W(DATA_W), .NUM_REGS(NUM_REGS), .ADDR_W(ADDR_W)) i_rd_b (
    .regs (disp_regs),
    .addr (addr_wb),
    .dout (port_b)
  );

  AST_READ_FROZEN: assert property (@(negedge clk) disable iff (clr)
    rd_mode |=> $stable(disp_regs)); // R3

  AST_NULL_WRITE: assert property (@(negedge clk) disable iff (clr)
    (!rd_mode && int'(addr_wb) >= NUM_REGS) |=> $stable(disp_regs)); // R6
endmodule

// File: tb/test_regfile_trio.sv
module test_regfile_trio;
  localparam int DW = 8;
  localparam int NR = 3;
  localparam int AW = 2;

  logic clk = 1'b0;
  logic clr, rd_mode;
  logic [AW-1:0] addr_a, addr_wb;
  logic [DW-1:0] wr_data;
  logic [DW-1:0] port_a, port_b;
  logic [NR*DW-1:0] disp_regs;

  int n_cmp = 0;
  int n_bad = 0;
  logic [DW-1:0] model [NR];

  always #10 clk = ~clk;

  regfile_trio i_regfile_trio (
    .clk(clk), .clr(clr), .rd_mode(rd_mode), .addr_a(addr_a),
    .addr_wb(addr_wb), .wr_data(wr_data), .port_a(port_a),
    .port_b(port_b), .disp_regs(disp_regs)
  );

  function automatic logic [DW-1:0] exp_rd(int a);
    return (a < NR) ? model[a] : '0;
  endfunction

  task automatic chk(string req, logic [DW-1:0] act, logic [DW-1:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic chk_disp(string req);
    for (int i = 0; i < NR; i++) chk(req, disp_regs[i*DW +: DW], model[i]);
  endtask

  // Drive after a rising edge, check the pre-edge ports, let the falling edge act,
  // update the model, then check the outputs after the edge.
  task automatic cyc(logic c, logic m, int a, int wb, logic [DW-1:0] d);
    @(posedge clk); #1;
    clr = c; rd_mode = m; addr_a = AW'(a); addr_wb = AW'(wb); wr_data = d;
    #4;
    chk("R4/R9 pre-edge port_a", port_a, exp_rd(a));
    chk("R5/R9 pre-edge port_b", port_b, exp_rd(wb));
    @(negedge clk); #5;
    if (c) begin
      for (int i = 0; i < NR; i++) model[i] = '0;
    end else if (!m && wb < NR) begin
      model[wb] = d;
    end
    chk("R4 post-edge port_a", port_a, exp_rd(a));
    chk("R5/R7 post-edge port_b", port_b, exp_rd(wb));
    chk_disp(c ? "R1/R8 disp" : (m ? "R3 disp" : "R2/R6/R10 disp"));
  endtask

  initial begin
    clr = 1'b1; rd_mode = 1'b1; addr_a = '0; addr_wb = '0; wr_data = '0;
    for (int i = 0; i < NR; i++) model[i] = '0;
    @(negedge clk); #5;
    chk_disp("R1 reset");

    for (int pass = 0; pass < 4; pass++) begin
      for (int wb = 0; wb < 4; wb++) begin
        cyc(1'b0, 1'b0, 3 - wb, wb, DW'((wb + 1) * 73 + pass * 29 + 5));
      end
      for (int a = 0; a < 4; a++) begin
        for (int wb = 0; wb < 4; wb++) begin
          cyc(1'b0, 1'b1, a, wb, DW'(a * 17 + wb * 91 + pass)); // R3 R4 R5 R7
        end
      end
      cyc(1'b0, 1'b0, 1, 3, 8'hFF); // R6
    end

    for (int wb = 0; wb < 4; wb++) begin
      cyc(1'b0, 1'b0, 0, wb, DW'(8'hA5 ^ wb));
      cyc(1'b1, 1'b0, wb, wb, 8'h3C); // R8
      cyc(1'b0, 1'b1, wb, (wb + 1) % 4, 8'h00);
    end
    cyc(1'b1, 1'b1, 2, 1, 8'h11); // R1

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #1_000_000;
    n_bad++; n_cmp++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule